// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line). A bus master uses it to read and write a small bank of 8-bit registers. The block samples both bus lines through two-stage synchronizers on the system clock. It recognises start, repeated-start and stop conditions, and compares each address byte against its own bus address. It keeps a register pointer that advances automatically, and it pulls the data line low to acknowledge bytes or to send read data. The clock line is never driven.

The 7-bit bus address has two parts. The upper four bits are the fixed value 1011. The lower three bits are taken from the low three bits of a register inside the bank. Up to eight of these slaves can therefore sit on one bus, and software can move a slave to a new address by writing that register.

Part of the register bank is treated as non-volatile. A transaction may write into that upper part. When it then ends with a stop, the slave raises a busy output for a programmable number of system clock cycles. While busy is high, the slave does not acknowledge its own address. A master can therefore poll with address bytes until the slave answers again.

Top module: `regSlaveTwoWire`

## Requirements
- R1: An address byte is accepted when bits 7..4 equal 1011 and bits 3..1 equal bits 2..0 of register `ADDR_REG` (register 0 by default). Bit 0 is the read/write flag, where 1 means read. An accepted address is acknowledged by driving `sdaDriveLow` high during the ninth clock pulse.
- R2: When an address byte does not match, it is not acknowledged. Every following byte up to the next start condition is neither acknowledged nor stored.
- R3: In a write transfer, the first byte after the address is loaded into the register pointer. Each later byte is stored at the pointer. Every byte of a write transfer is acknowledged.
- R4: After each data byte is written or read, the pointer advances by one. It wraps from `REG_COUNT-1` to 0.
- R5: Read data is sent most significant bit first, starting at the current pointer. A further byte follows after each master acknowledge. After a master NACK the slave releases the data line.
- R6: A read can be made from a chosen register in one sequence: start, write address, pointer byte, repeated start, read address, data byte.
- R7: Consider a transaction that writes any register with an index of at least `NV_FIRST` and then ends with a stop. After that stop, `busy` is high for exactly `BUSY_CYCLES` system clock cycles. During that time the slave's own address is not acknowledged, and once `busy` falls the address is acknowledged again.
- R8: Transactions that write only registers below `NV_FIRST` never raise `busy`.
- R9: A start or stop condition that arrives before all eight bits of a byte abandons that byte. Nothing is stored and the pointer does not advance.
- R10: After reset, `sdaDriveLow` and `busy` are low. `sdaDriveLow` changes only while the clock line is low.
- R11: A value written to register `ADDR_REG` takes effect as the slave's new address from the next start condition onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | When high, the pad pulls the data line low |
| busy | output | 1 | High during the non-volatile write-time window |

## Verification
The hardest situation to reach is an address poll that lands inside the busy window. The poll has to follow the stop of a non-volatile write closely enough that the slave compares the address while its counter is still running. To get there, the bench drives bus cycles with a fixed half period. It issues the poll directly after the stop, and at the time the address is compared it also checks that `busy` is still high. Only after the expected number of busy cycles has been counted does it poll again.

The bench also builds mid-byte aborts. It sends a partial run of bits and then cuts it off with either a repeated start or a stop. It then reads the register back to confirm that nothing was stored and that the pointer did not move.

// File: rtl/twsPkg.sv
package twsPkg;

  localparam logic [3:0] DEV_PREFIX = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twsState_e;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } twsStrobe_t;

endpackage

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int NV_FIRST    = 4,
  parameter int BUSY_CYCLES = 300,
  parameter int ADDR_REG    = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  twsStrobe_t strobe,
  output logic       sclHigh,
  output logic       sclRise,
  output logic       sclFall,
  output logic       startDet,
  output logic       stopDet,
  output logic       sdaBit,
  output logic       addrMatch,
  output logic       rwBit,
  output logic       txBit,
  output logic       busy
);

  localparam int PTR_W = $clog2(REG_COUNT);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [PTR_W-1:0] NV_LO   = PTR_W'(NV_FIRST);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BUSY_CYCLES);

  logic [1:0]       sclSync, sdaSync;
  logic             sclPrev, sdaPrev;
  logic [7:0]       rxByte, txByte;
  logic [PTR_W-1:0] ptr;
  logic             nvDirty;
  logic [CNT_W-1:0] busyCnt;
  logic [7:0]       regs [REG_COUNT];

  // two-stage synchronizers and one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclHigh  = sclSync[1];
  assign sdaBit   = sdaSync[1];
  assign sclRise  = sclSync[1] & ~sclPrev;
  assign sclFall  = ~sclSync[1] & sclPrev;
  assign startDet = sclSync[1] & sclPrev & sdaPrev & ~sdaSync[1];
  assign stopDet  = sclSync[1] & sclPrev & ~sdaPrev & sdaSync[1];

  // shifters, pointer, non-volatile tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txByte  <= '0;
      ptr     <= '0;
      nvDirty <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaBit};

      if (strobe.loadTx)       txByte <= regs[ptr];
      else if (strobe.shiftTx) txByte <= {txByte[6:0], 1'b0};

      if (strobe.loadPtr)                         ptr <= rxByte[PTR_W-1:0];
      else if (strobe.writeReg || strobe.incPtr)  ptr <= ptr + 1'b1;

      if (stopDet)                                nvDirty <= 1'b0;
      else if (strobe.writeReg && (ptr >= NV_LO)) nvDirty <= 1'b1;

      if (stopDet && nvDirty)  busyCnt <= CNT_TOP;
      else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
    end
  end

  // register bank, one flop group per entry
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= '0;
      else if (strobe.writeReg && (ptr == PTR_W'(g)))
        regs[g] <= rxByte;
    end
  end

  assign busy      = (busyCnt != '0);
  assign rwBit     = rxByte[0];
  assign txBit     = txByte[7];
  assign addrMatch = (rxByte[7:4] == DEV_PREFIX) &&
                     (rxByte[3:1] == regs[ADDR_REG][2:0]) && !busy;

endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaBit,
  input  logic       addrMatch,
  input  logic       rwBit,
  input  logic       txBit,
  output twsStrobe_t strobe,
  output twsState_e  state,
  output logic       sdaDriveLow
);

  logic [3:0] bitCnt;
  logic       rwFlag, expectPtr, masterAck;
  logic       byteFull;

  assign byteFull = (bitCnt == 4'd8);

  always_comb begin
    strobe = '0;
    case (state)
      ST_ADDR: strobe.shiftIn = sclRise && !byteFull;
      ST_RX: begin
        strobe.shiftIn  = sclRise && !byteFull;
        strobe.loadPtr  = sclFall && byteFull && expectPtr;
        strobe.writeReg = sclFall && byteFull && !expectPtr;
      end
      ST_ADDR_ACK: strobe.loadTx = sclFall && rwFlag;
      ST_TX: begin
        strobe.shiftTx = sclFall && !byteFull;
        strobe.incPtr  = sclFall && byteFull;
      end
      ST_TX_ACK: strobe.loadTx = sclFall && masterAck;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rwFlag    <= 1'b0;
      expectPtr <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && !byteFull) bitCnt <= bitCnt + 4'd1;
          if (sclFall && byteFull) begin
            if (addrMatch) begin
              state  <= ST_ADDR_ACK;
              rwFlag <= rwBit;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          bitCnt    <= '0;
          expectPtr <= !rwFlag;
          state     <= rwFlag ? ST_TX : ST_RX;
        end
        ST_RX: begin
          if (sclRise && !byteFull) bitCnt <= bitCnt + 4'd1;
          if (sclFall && byteFull) state <= ST_RX_ACK;
        end
        ST_RX_ACK: if (sclFall) begin
          bitCnt    <= '0;
          expectPtr <= 1'b0;
          state     <= ST_RX;
        end
        ST_TX: begin
          if (sclRise && !byteFull) bitCnt <= bitCnt + 4'd1;
          if (sclFall && byteFull) state <= ST_TX_ACK;
        end
        ST_TX_ACK: begin
          if (sclRise) masterAck <= !sdaBit;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                       ((state == ST_TX) && !txBit);

endmodule

// File: rtl/regSlaveTwoWire.sv
module regSlaveTwoWire
  import twsPkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int NV_FIRST    = 4,
  parameter int BUSY_CYCLES = 300,
  parameter int ADDR_REG    = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  output logic busy
);

  twsStrobe_t strobe;
  twsState_e  ctrlState;
  logic sclHigh, sclRise, sclFall, startDet, stopDet;
  logic sdaBit, addrMatch, rwBit, txBit;

  twsDatapath #(
    .REG_COUNT(REG_COUNT), .NV_FIRST(NV_FIRST),
    .BUSY_CYCLES(BUSY_CYCLES), .ADDR_REG(ADDR_REG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .sclHigh(sclHigh), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit), .busy(busy)
  );

  twsControl u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .state(ctrlState), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/twsChecker.sv
module twsChecker
  import twsPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclHigh,
  input logic      startDet,
  input logic      stopDet,
  input logic      sdaDriveLow,
  input logic      busy,
  input twsState_e ctrlState
);

  p_start_to_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (ctrlState == ST_ADDR));

  p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (ctrlState == ST_IDLE));

  p_no_ack_while_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlState == ST_ADDR_ACK) && ($past(ctrlState) != ST_ADDR_ACK)) |-> !$past(busy));

  p_busy_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet));

  p_sda_quiet_scl_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclHigh && $past(sclHigh)) |-> $stable(sdaDriveLow));

endmodule

bind regSlaveTwoWire twsChecker u_chk (.*);

// File: tb/sim_regSlaveTwoWire.sv
module sim_regSlaveTwoWire;

  localparam int H     = 8;
  localparam int REGS  = 8;
  localparam int BUSYN = 300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclM, sdaM;
  logic sdaDriveLow, busy;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaDriveLow;

  regSlaveTwoWire u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int busyCount = 0;
  int violations = 0;
  logic done = 1'b0;
  logic sclPrevM = 1'b1;
  logic drvPrev = 1'b0;
  logic [7:0] model [REGS];
  logic [2:0] devLow = 3'd0;

  always @(negedge clk) begin
    if (busy) busyCount++;
    if (rstN && sclM && sclPrevM && (sdaDriveLow != drvPrev)) violations++;
    sclPrevM = sclM;
    drvPrev  = sdaDriveLow;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hw(); sclM = 1'b1; hw(); sdaM = 1'b0; hw(); sclM = 1'b0; hw();
  endtask

  task automatic busStop();
    sdaM = 1'b0; hw(); sclM = 1'b1; hw(); sdaM = 1'b1; hw();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; hw(); sclM = 1'b1; hw(); sclM = 1'b0; hw();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) putBit(b[7-i]);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; hw(); sclM = 1'b1; hw();
    acked = !sdaLine;
    sclM = 1'b0; hw();
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); sclM = 1'b1; hw(); d[i] = sdaLine; sclM = 1'b0; hw();
    end
    sdaM = !ackIt; hw(); sclM = 1'b1; hw(); sclM = 1'b0; hw();
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {4'b1011, devLow, rd};
  endfunction

  task automatic writeRegs(input logic [7:0] ptr, input int n,
                           input logic [7:0] first, input logic [7:0] step, input string tag);
    logic a;
    busStart();
    sendByte(devByte(1'b0), a); check(a, {tag, " address ack"}, a, 1);
    sendByte(ptr, a);           check(a, {tag, " pointer ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = first + step * 8'(k);
      sendByte(v, a); check(a, {tag, " data ack"}, a, 1);
      model[(int'(ptr) + k) % REGS] = v;
    end
    busStop();
  endtask

  task automatic readRegs(input logic [7:0] ptr, input int n, input string tag);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(devByte(1'b0), a); check(a, {tag, " write address ack"}, a, 1);
    sendByte(ptr, a);           check(a, {tag, " pointer ack"}, a, 1);
    busStart();
    sendByte(devByte(1'b1), a); check(a, {tag, " read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      getByte(k != n - 1, d);
      check(d == model[(int'(ptr) + k) % REGS], {tag, " read data"}, d,
            model[(int'(ptr) + k) % REGS]);
    end
    check(sdaDriveLow == 1'b0, {tag, " released after NACK"}, sdaDriveLow, 0);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int base;
    for (int i = 0; i < REGS; i++) model[i] = 8'h00;
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    repeat (5) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R10 reset drive", sdaDriveLow, 0);
    check(busy == 1'b0, "R10 reset busy", busy, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R3 R8: volatile writes to registers 1..3
    base = busyCount;
    writeRegs(8'd1, 3, 8'h11, 8'h11, "R3");
    repeat (20) @(negedge clk);
    check(busyCount == base, "R8 no busy after volatile write", busyCount - base, 0);

    // R2: wrong prefix and wrong low bits, later bytes ignored
    busStart();
    sendByte(8'hA0, a); check(!a, "R2 prefix mismatch no ack", a, 0);
    sendByte(8'd2, a);  check(!a, "R2 ignored pointer", a, 0);
    sendByte(8'hEE, a); check(!a, "R2 ignored data", a, 0);
    busStop();
    busStart();
    sendByte(8'hB2, a); check(!a, "R1 low address bits mismatch", a, 0);
    sendByte(8'd2, a);  check(!a, "R2 ignored pointer 2", a, 0);
    sendByte(8'hEE, a); check(!a, "R2 ignored data 2", a, 0);
    busStop();

    // R5 R6 R4: dummy-write read of 1..3 with auto-increment
    readRegs(8'd1, 3, "R6 R5");

    // R7: non-volatile write, poll during busy, then after
    base = busyCount;
    writeRegs(8'd4, 3, 8'hA4, 8'h01, "R7");
    busStart();
    sendByte(devByte(1'b0), a);
    check(busy == 1'b1, "R7 busy during poll", busy, 1);
    check(!a, "R7 no address ack while busy", a, 0);
    busStop();
    repeat (BUSYN + 100) @(negedge clk);
    check(busyCount - base == BUSYN, "R7 busy length", busyCount - base, BUSYN);
    busStart();
    sendByte(devByte(1'b0), a); check(a, "R7 ack after busy", a, 1);
    busStop();
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R7 no busy after empty write", busy, 0);

    // R4: read wrap 6,7,0,1
    readRegs(8'd6, 4, "R4 wrap read");
    // R4: write wrap 7 -> 0 with address bits kept at 000
    writeRegs(8'd7, 2, 8'h70, 8'h90, "R4 wrap write");
    repeat (BUSYN + 50) @(negedge clk);
    readRegs(8'd7, 2, "R4 wrap readback");

    // R9: abort by repeated start after 5 bits
    busStart();
    sendByte(devByte(1'b0), a); check(a, "R9 address ack", a, 1);
    sendByte(8'd2, a);          check(a, "R9 pointer ack", a, 1);
    sendBits(8'hFF, 5);
    busStart();
    sendByte(devByte(1'b1), a); check(a, "R9 read address ack", a, 1);
    getByte(1'b0, d);
    check(d == model[2], "R9 repeated start abort", d, model[2]);
    busStop();
    // R9: abort by stop after 4 bits
    busStart();
    sendByte(devByte(1'b0), a); check(a, "R9 address ack 2", a, 1);
    sendByte(8'd3, a);          check(a, "R9 pointer ack 2", a, 1);
    sendBits(8'h00, 4);
    busStop();
    readRegs(8'd3, 1, "R9 stop abort");

    // R11: move the slave to address low bits 101
    writeRegs(8'd0, 1, 8'h05, 8'h00, "R11");
    busStart();
    sendByte(8'hB0, a); check(!a, "R11 old address refused", a, 0);
    busStop();
    devLow = 3'b101;
    readRegs(8'd1, 2, "R11 new address");

    check(violations == 0, "R10 drive change while clock high", violations, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule